// File: doc/BRIEF.md
# Address-Seeded Memory Pattern Checker

This block runs a write and read-back test over a series of test windows in an external memory. It reaches the memory through a word-wide request port with valid/ready handshaking, and it drives a separate delay-setting register port. Each window is handled in four steps. First the delay register is returned to its default value. Then every byte of the window is overwritten with 0x1F. Next every word is rewritten with a value derived from its own address. Finally a candidate delay setting is applied and each word is read back and compared.

The test runs until one of two things happens. Either the window sequence runs off the end of the selected memory size, and the result is pass, or a word reads back wrong, and the result is fail. A single start pulse launches the test. Memory size, window offset, data bias and candidate delay are captured at that moment. The result appears as a one-cycle done pulse with the pass flag beside it.

Top module: `memchk`

## Requirements
- R1: After reset the block is idle: busy, done, pass, memReqValid and dlyWrEn are all low.
- R2: A start pulse while idle launches the test and captures sizeSel, offset, bias and candDelay. A start while busy is ignored, and so are input changes during the run: there is still exactly one done, and the window sequence uses the captured values.
- R3: At the start of each window the delay port is written once with 16'h7474, before any memory access of that window. In the first busy cycle, dlyWrEn is high with that value.
- R4: The fill phase writes WIN_WORDS words (default 1024, which is 128 lines of 32 bytes). The data of every fill word is 32'h1F1F1F1F. The writes go to ascending byte addresses base + 4*i.
- R5: The pattern phase then writes word i, at address base + 4*i, with the value base + i + bias (modulo 2^32), in ascending order.
- R6: Once the last pattern word is written, the delay port is written once with the captured candidate setting. Only after that do the read requests of the window start.
- R7: Reads go in ascending order, and word i is compared with base + i + bias. The first mismatch ends the whole test with pass low, and no further memory or delay request is issued.
- R8: The first window base is 0. Each later base is the previous base + (size >> 6) + offset. A window is tested only while its base is below size − 4*WIN_WORDS.
- R9: The sizeSel encoding is 0 for 0x02000000 bytes, 1 for 0x04000000, 2 for 0x08000000 and 3 for 0x10000000.
- R10: Only one request is outstanding at a time. An unacknowledged request keeps memReqValid, memAddr, memWe and memWdata stable until memReqReady. Read data is taken in the cycle memReqReady is high, and addresses are word aligned.
- R11: done is high for exactly one cycle. pass is high only together with done. busy is low in the cycle after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch pulse, honoured only while idle |
| sizeSel | input | 2 | Memory size select (R9) |
| offset | input | 32 | Extra byte spacing between windows |
| bias | input | 32 | Value added to each pattern word |
| candDelay | input | 16 | Delay setting applied before read-back |
| busy | output | 1 | Test in progress |
| done | output | 1 | One-cycle end-of-test pulse |
| pass | output | 1 | Result, valid with done |
| memReqValid | output | 1 | Memory request valid |
| memReqReady | input | 1 | Memory accepts request / read data valid |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | 32 | Byte address of the word |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, sampled while memReqReady is high |
| dlyWrEn | output | 1 | Delay register write strobe |
| dlyWrData | output | 16 | Delay register write value |

## Verification
A start seen at a rising edge produces the default delay write in the next cycle, and the first fill request follows one cycle later. Each memory handshake completes at the edge where valid and ready are both high, and done rises in the cycle after the final read acknowledge or the mismatching one. The bench drives ready and read data on falling edges and samples every request, delay write and done pulse on those same falling edges, when the registered outputs have settled. Each transaction is therefore attributed to exactly the cycle in which it completes. Ready is held low on a fixed fraction of cycles so that the hold rule is exercised throughout each run.

// File: rtl/memchk_pkg.sv
package memchk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DLY_DEF,
    ST_FILL,
    ST_PAT,
    ST_DLY_CAND,
    ST_READ,
    ST_DONE
  } state_e;

  // Strobes and selects from control to datapath
  typedef struct packed {
    logic loadCfg;
    logic clrIdx;
    logic incIdx;
    logic advBase;
    logic selPattern;
    logic selCand;
  } strobe_t;

endpackage

// File: rtl/memchk_dp.sv
module memchk_dp
  import memchk_pkg::*;
#(
  parameter int unsigned AW          = 32,
  parameter int unsigned WIN_WORDS   = 1024,
  parameter int unsigned DLY_W       = 16,
  parameter logic [15:0] DLY_DEFAULT = 16'h7474,
  parameter logic [7:0]  FILL_BYTE   = 8'h1F,
  parameter logic [AW-1:0] MIN_SIZE  = 'h0200_0000,
  parameter int unsigned STEP_SHIFT  = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [1:0]       sizeSel,
  input  logic [AW-1:0]    offset,
  input  logic [AW-1:0]    bias,
  input  logic [DLY_W-1:0] candDelay,
  input  logic [AW-1:0]    memRdata,
  output logic [AW-1:0]    memAddr,
  output logic [AW-1:0]    memWdata,
  output logic [DLY_W-1:0] dlyWrData,
  output logic             idxLast,
  output logic             nextOk,
  output logic             rdMatch
);
  localparam int unsigned IDX_W     = $clog2(WIN_WORDS);
  localparam int unsigned WB        = AW / 8;
  localparam int unsigned WSH       = $clog2(WB);
  localparam int unsigned WIN_BYTES = WIN_WORDS * WB;

  logic [AW-1:0]    sizeQ, offsetQ, biasQ, baseQ;
  logic [DLY_W-1:0] candQ;
  logic [IDX_W-1:0] idxQ;
  logic [AW-1:0]    fillWord, expWord;
  logic [AW+1:0]    nextBase, limit;

  // Fill word: the fill byte repeated across every byte lane
  for (genvar b = 0; b < WB; b++) begin : g_fill
    assign fillWord[b*8 +: 8] = FILL_BYTE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sizeQ   <= '0;
      offsetQ <= '0;
      biasQ   <= '0;
      candQ   <= '0;
    end else if (strb.loadCfg) begin
      sizeQ   <= MIN_SIZE << sizeSel;
      offsetQ <= offset;
      biasQ   <= bias;
      candQ   <= candDelay;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ <= '0;
    end else if (strb.loadCfg) begin
      baseQ <= '0;
    end else if (strb.advBase) begin
      baseQ <= nextBase[AW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxQ <= '0;
    end else if (strb.clrIdx) begin
      idxQ <= '0;
    end else if (strb.incIdx) begin
      idxQ <= idxQ + 1'b1;
    end
  end

  always_comb begin
    expWord   = baseQ + AW'(idxQ) + biasQ;
    memAddr   = baseQ + (AW'(idxQ) << WSH);
    memWdata  = strb.selPattern ? expWord : fillWord;
    dlyWrData = strb.selCand ? candQ : DLY_W'(DLY_DEFAULT);
    rdMatch   = (memRdata == expWord);
    idxLast   = (idxQ == IDX_W'(WIN_WORDS - 1));
    nextBase  = {2'b00, baseQ} + {2'b00, (sizeQ >> STEP_SHIFT)} + {2'b00, offsetQ};
    limit     = {2'b00, sizeQ} - (AW+2)'(WIN_BYTES);
    nextOk    = (nextBase < limit);
  end

endmodule

// File: rtl/memchk_ctrl.sv
module memchk_ctrl
  import memchk_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    memReqReady,
  input  logic    idxLast,
  input  logic    nextOk,
  input  logic    rdMatch,
  output strobe_t strb,
  output logic    memReqValid,
  output logic    memWe,
  output logic    dlyWrEn,
  output logic    busy,
  output logic    done,
  output logic    pass
);
  state_e stateQ, stateD;
  logic   okQ, okD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      okQ    <= 1'b0;
    end else begin
      stateQ <= stateD;
      okQ    <= okD;
    end
  end

  always_comb begin
    stateD      = stateQ;
    okD         = okQ;
    strb        = '0;
    memReqValid = 1'b0;
    memWe       = 1'b0;
    dlyWrEn     = 1'b0;
    done        = 1'b0;
    pass        = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (start) begin
          strb.loadCfg = 1'b1;
          strb.clrIdx  = 1'b1;
          okD          = 1'b1;
          stateD       = ST_DLY_DEF;
        end
      end
      ST_DLY_DEF: begin
        dlyWrEn = 1'b1;
        stateD  = ST_FILL;
      end
      ST_FILL: begin
        memReqValid = 1'b1;
        memWe       = 1'b1;
        if (memReqReady) begin
          if (idxLast) begin
            strb.clrIdx = 1'b1;
            stateD      = ST_PAT;
          end else begin
            strb.incIdx = 1'b1;
          end
        end
      end
      ST_PAT: begin
        memReqValid     = 1'b1;
        memWe           = 1'b1;
        strb.selPattern = 1'b1;
        if (memReqReady) begin
          if (idxLast) begin
            strb.clrIdx = 1'b1;
            stateD      = ST_DLY_CAND;
          end else begin
            strb.incIdx = 1'b1;
          end
        end
      end
      ST_DLY_CAND: begin
        dlyWrEn      = 1'b1;
        strb.selCand = 1'b1;
        stateD       = ST_READ;
      end
      ST_READ: begin
        memReqValid     = 1'b1;
        strb.selPattern = 1'b1;
        if (memReqReady) begin
          if (!rdMatch) begin
            okD    = 1'b0;
            stateD = ST_DONE;
          end else if (idxLast) begin
            if (nextOk) begin
              strb.advBase = 1'b1;
              strb.clrIdx  = 1'b1;
              stateD       = ST_DLY_DEF;
            end else begin
              stateD = ST_DONE;
            end
          end else begin
            strb.incIdx = 1'b1;
          end
        end
      end
      ST_DONE: begin
        done   = 1'b1;
        pass   = okQ;
        stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  assign busy = (stateQ != ST_IDLE);

endmodule

// File: rtl/memchk.sv
module memchk
  import memchk_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned WIN_WORDS = 1024,
  parameter int unsigned DLY_W     = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [1:0]       sizeSel,
  input  logic [AW-1:0]    offset,
  input  logic [AW-1:0]    bias,
  input  logic [DLY_W-1:0] candDelay,
  output logic             busy,
  output logic             done,
  output logic             pass,
  output logic             memReqValid,
  input  logic             memReqReady,
  output logic             memWe,
  output logic [AW-1:0]    memAddr,
  output logic [AW-1:0]    memWdata,
  input  logic [AW-1:0]    memRdata,
  output logic             dlyWrEn,
  output logic [DLY_W-1:0] dlyWrData
);
  strobe_t strb;
  logic    idxLast, nextOk, rdMatch;

  memchk_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .memReqReady(memReqReady),
    .idxLast(idxLast), .nextOk(nextOk), .rdMatch(rdMatch), .strb(strb),
    .memReqValid(memReqValid), .memWe(memWe), .dlyWrEn(dlyWrEn),
    .busy(busy), .done(done), .pass(pass)
  );

  memchk_dp #(.AW(AW), .WIN_WORDS(WIN_WORDS), .DLY_W(DLY_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .sizeSel(sizeSel), .offset(offset),
    .bias(bias), .candDelay(candDelay), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .dlyWrData(dlyWrData),
    .idxLast(idxLast), .nextOk(nextOk), .rdMatch(rdMatch)
  );

endmodule

// File: rtl/memchk_sva.sv
module memchk_sva #(
  parameter int unsigned AW    = 32,
  parameter int unsigned DLY_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             pass,
  input logic             memReqValid,
  input logic             memReqReady,
  input logic             memWe,
  input logic [AW-1:0]    memAddr,
  input logic [AW-1:0]    memWdata,
  input logic             dlyWrEn,
  input logic [DLY_W-1:0] dlyWrData
);
  localparam int unsigned WSH = $clog2(AW / 8);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!memReqValid && !dlyWrEn && !done));

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && busy && !done) |=> busy);

  // R3
  first_dly_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (dlyWrEn && dlyWrData == DLY_W'(16'h7474)));

  // R6
  dly_mem_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    dlyWrEn |-> !memReqValid);

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=>
      (memReqValid && $stable(memAddr) && $stable(memWe) && $stable(memWdata)));

  // R10
  addr_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> (memAddr[WSH-1:0] == '0));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R11
  pass_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    pass |-> done);

  // R11
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

endmodule

bind memchk memchk_sva #(.AW(AW), .DLY_W(DLY_W)) u_sva (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done), .pass(pass),
  .memReqValid(memReqValid), .memReqReady(memReqReady), .memWe(memWe),
  .memAddr(memAddr), .memWdata(memWdata), .dlyWrEn(dlyWrEn), .dlyWrData(dlyWrData)
);

// File: tb/memchk_test.sv
module memchk_test;
  localparam int          TW    = 16;
  localparam logic [31:0] FILLW = 32'h1F1F_1F1F;
  localparam logic [15:0] DDEF  = 16'h7474;

  logic        clk, rstN, start;
  logic [1:0]  sizeSel;
  logic [31:0] offset, bias;
  logic [15:0] candDelay;
  logic        busy, done, pass;
  logic        memReqValid, memReqReady, memWe;
  logic [31:0] memAddr, memWdata, memRdata;
  logic        dlyWrEn;
  logic [15:0] dlyWrData;

  memchk #(.WIN_WORDS(TW)) uut (
    .clk(clk), .rstN(rstN), .start(start), .sizeSel(sizeSel), .offset(offset),
    .bias(bias), .candDelay(candDelay), .busy(busy), .done(done), .pass(pass),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata),
    .dlyWrEn(dlyWrEn), .dlyWrData(dlyWrData)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  int checks = 0, errors = 0, cyc = 0;

  // memory model and monitor state
  logic [31:0] mem [logic [31:0]];
  int winCnt, fillCnt, patCnt, rdCnt, totalReads, seqErr, patErr, stabErr;
  int doneCnt, reqAfter, passErr, phase, readyCnt;
  logic        lastPass, seenDone, prevPend;
  logic [31:0] curBase, expBias, step, prevAddr, faultAddr, rd;
  logic [15:0] dlyReg, expCand, badDelay;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected under 190000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  always @(negedge clk) begin
    readyCnt = readyCnt + 1;
    memReqReady = memReqValid && (readyCnt % 3 != 0);
    rd = mem.exists(memAddr) ? mem[memAddr] : 32'hDEAD_BEEF;
    if (memAddr == faultAddr) rd = rd ^ 32'h1;
    if (dlyReg == badDelay)   rd = rd ^ 32'h100;
    memRdata = rd;
    if (prevPend && (!memReqValid || memAddr != prevAddr)) stabErr++;
    prevPend = memReqValid && !memReqReady;
    prevAddr = memAddr;
    if (seenDone && (memReqValid || dlyWrEn)) reqAfter++;
    if (dlyWrEn) begin
      dlyReg = dlyWrData;
      if (dlyWrData == DDEF) begin
        if (phase != 0 && !(phase == 3 && rdCnt == TW)) seqErr++;
        curBase = (winCnt == 0) ? 32'h0 : curBase + step;
        winCnt++;
        fillCnt = 0; patCnt = 0; rdCnt = 0; phase = 1;
      end else begin
        if (phase != 2 || patCnt != TW || dlyWrData != expCand) seqErr++;
        phase = 3;
      end
    end
    if (memReqValid && memReqReady) begin
      if (memWe) begin
        if (phase == 1) begin
          if (memAddr != curBase + 32'(fillCnt * 4) || memWdata != FILLW) seqErr++;
          fillCnt++;
          if (fillCnt == TW) phase = 2;
        end else if (phase == 2) begin
          if (memAddr != curBase + 32'(patCnt * 4) ||
              memWdata != curBase + 32'(patCnt) + expBias) patErr++;
          patCnt++;
        end else seqErr++;
        mem[memAddr] = memWdata;
      end else begin
        if (phase != 3 || memAddr != curBase + 32'(rdCnt * 4)) seqErr++;
        rdCnt++;
        totalReads++;
      end
    end
    if (done) begin
      doneCnt++;
      lastPass = pass;
      seenDone = 1'b1;
    end
    if (pass && !done) passErr++;
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int expWin(input logic [1:0] sz, input logic [31:0] off);
    longint size = longint'(32'h0200_0000) << sz;
    longint st   = (size >> 6) + longint'(off);
    longint b    = 0;
    int n = 0;
    while (b < size - TW * 4) begin
      n++;
      b += st;
    end
    return n;
  endfunction

  task automatic clearMon();
    winCnt = 0; fillCnt = 0; patCnt = 0; rdCnt = 0; totalReads = 0;
    seqErr = 0; patErr = 0; stabErr = 0; doneCnt = 0; reqAfter = 0; passErr = 0;
    phase = 0; seenDone = 1'b0; lastPass = 1'b0; prevPend = 1'b0; dlyReg = 16'h0;
    mem.delete();
  endtask

  // Launch a test; optionally re-pulse start with other inputs mid-run
  task automatic runTest(input logic [1:0] sz, input logic [31:0] off, input logic [31:0] bs,
                         input logic [15:0] cand, input logic [15:0] bad,
                         input logic [31:0] fault, input bit restartMid);
    @(negedge clk);
    clearMon();
    sizeSel = sz; offset = off; bias = bs; candDelay = cand;
    badDelay = bad; faultAddr = fault; expBias = bs; expCand = cand;
    step = ((32'h0200_0000 << sz) >> 6) + off;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (restartMid) begin
      repeat (200) @(negedge clk);
      sizeSel = 2'd3; offset = 32'h777; bias = 32'h9; candDelay = 16'h0BAD; badDelay = 16'h0BAD;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int w = 0; w < 60000 && doneCnt == 0; w++) @(negedge clk);
    repeat (10) @(negedge clk);
  endtask

  task automatic t_reset();
    check(busy == 0 && done == 0 && pass == 0, "R1 status idle", {busy, done, pass}, 0);
    check(memReqValid == 0 && dlyWrEn == 0, "R1 ports quiet", {memReqValid, dlyWrEn}, 0);
  endtask

  task automatic t_pass(input logic [1:0] sz, input logic [31:0] off, input logic [31:0] bs,
                        input logic [15:0] cand);
    int n = expWin(sz, off);
    runTest(sz, off, bs, cand, 16'hFFFF, 32'hFFFF_FFFF, 1'b0);
    check(doneCnt == 1 && lastPass == 1, "R11 single done with pass", doneCnt, 1);
    check(winCnt == n, "R8 R9 window count", winCnt, n);
    check(seqErr == 0, "R3 R4 R6 sequence and fill", seqErr, 0);
    check(patErr == 0, "R5 pattern data", patErr, 0);
    check(totalReads == n * TW, "R7 all words read", totalReads, n * TW);
    check(stabErr == 0, "R10 request hold", stabErr, 0);
    check(passErr == 0 && reqAfter == 0 && busy == 0, "R11 pass only with done, idle after",
          passErr + reqAfter + int'(busy), 0);
  endtask

  task automatic t_fault();
    logic [31:0] st = (32'h0200_0000 >> 6) + 32'h200;
    runTest(2'd0, 32'h200, 32'h5, 16'h3C3C, 16'hFFFF, 2 * st + 20, 1'b0);
    check(doneCnt == 1 && lastPass == 0, "R7 fail result", lastPass, 0);
    check(winCnt == 3, "R7 stops in third window", winCnt, 3);
    check(totalReads == 2 * TW + 6, "R7 stops at first mismatch", totalReads, 2 * TW + 6);
    check(reqAfter == 0, "R7 no request after fail", reqAfter, 0);
  endtask

  task automatic t_badDelay();
    runTest(2'd1, 32'h0, 32'h7, 16'h0BAD, 16'h0BAD, 32'hFFFF_FFFF, 1'b0);
    check(lastPass == 0 && doneCnt == 1, "R6 candidate applied before reads", lastPass, 0);
    check(totalReads == 1 && winCnt == 1, "R6 R7 first read fails", totalReads, 1);
  endtask

  task automatic t_restart();
    int n = expWin(2'd0, 32'h40);
    runTest(2'd0, 32'h40, 32'h3, 16'h5A5A, 16'hFFFF, 32'hFFFF_FFFF, 1'b1);
    check(doneCnt == 1, "R2 start while busy ignored", doneCnt, 1);
    check(lastPass == 1 && patErr == 0 && seqErr == 0, "R2 latched inputs kept",
          patErr + seqErr, 0);
    check(winCnt == n, "R2 window sequence from captured inputs", winCnt, n);
  endtask

  initial begin
    rstN = 1'b0; start = 1'b0; sizeSel = 2'd0; offset = '0; bias = '0; candDelay = '0;
    memReqReady = 1'b0; memRdata = '0; readyCnt = 0;
    badDelay = 16'hFFFF; faultAddr = 32'hFFFF_FFFF; expBias = '0; expCand = '0;
    step = '0; curBase = '0; prevAddr = '0; rd = '0;
    clearMon();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_pass(2'd0, 32'h0, 32'h3, 16'h5A5A);
    t_pass(2'd3, 32'h480, 32'h1, 16'h1234);
    t_pass(2'd1, 32'h100, 32'hFFFF_FFF0, 16'h0F0F);
    t_pass(2'd2, 32'h400, 32'h0, 16'h00FF);
    t_fault();
    t_badDelay();
    t_restart();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule